// File: doc/BRIEF.md
# Single-Slot Shared Mailbox

This block is one message slot shared by two processors. A sending processor deposits a message through a small word-addressed register window, and that act also raises a stored "full" flag. The receiving processor reads the message and then writes zero to hand the slot back. The flag is never raised or lowered by a separate strobe. It is a stored bit of a register, and plain writes change it.

A parameter selects one of two layouts. In the narrow layout a single 32-bit word holds a 31-bit payload in bits [30:0] and the full flag in bit 31. In the wide layout four 32-bit data words hold the payload, and a separate tag word carries the flag in its bit 31. Senders fill the data words first and set the tag last. Receivers clear the data words and then the tag.

Two level-sensitive status outputs report whether the slot is full or empty. Two one-bit enables gate these into interrupt requests. Collecting requests from several slots is left to logic outside this block. The read port is combinational: `rdData` follows `addr` in the same cycle.

Top module: `mbox_shared`

## Requirements
- R1: After reset, every stored word and both enables are zero, so `fullOut`=0, `emptyOut`=1, both interrupt requests are 0, and every offset reads 0.
- R2: In the narrow layout (WIDE=0), a write to offset 0x00 stores all 32 bits, and that offset reads them back. From the clock edge that takes the write, `fullOut` equals bit 31 of the stored word.
- R3: Writing 0x0000_0000 to the flag-carrying word clears the payload and the flag together. This word is offset 0x00 when narrow and 0x40 when wide. `emptyOut` is 1 from the next edge.
- R4: Offset 0x04 holds the full-interrupt enable and offset 0x08 holds the empty-interrupt enable. Each keeps only bit 0 of the written value and reads back zero-extended.
- R5: `fullIrq` = `fullOut` AND full-enable, and `emptyIrq` = `emptyOut` AND empty-enable. Both are combinational from the stored state.
- R6: In the wide layout (WIDE=1), the tag is at 0x40 and data words 0..3 are at 0x48, 0x4C, 0x50 and 0x54. `fullOut` is bit 31 of the tag. Writing a data word never changes `fullOut`.
- R7: Offsets that do not exist in the selected layout read 0, and writes to them change no state. Offsets 0x40–0x54 do not exist when narrow, 0x00 does not exist when wide, and any other offset does not exist in either layout.
- R8: `emptyOut` is always the inverse of `fullOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte offset into the register window |
| wrData | input | 32 | Write value |
| rdData | output | 32 | Combinational read of the register at `addr` |
| fullOut | output | 1 | Stored full flag |
| emptyOut | output | 1 | Inverse of the full flag |
| fullIrq | output | 1 | Full condition gated by its enable |
| emptyIrq | output | 1 | Empty condition gated by its enable |

## Verification
A write lands on the first rising edge after `wrEn` is seen. The stored word, the flags and the interrupt requests all change at that edge. `rdData` has no register, so it reflects a new `addr` within the same cycle. The bench drives every write on a falling edge and lowers `wrEn` on the next falling edge. It then checks the flags and requests right away, half a cycle after the edge that took the write. For readback it presents the offset on a falling edge and samples `rdData` one nanosecond later. Both layouts run side by side on the same stimulus, so each write is also a probe of R7 for the layout that lacks that offset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W     = 32;
  localparam int DATA_WORDS = 4;
  localparam int IDX_W      = $clog2(DATA_WORDS);
  localparam int FLAG_BIT   = WORD_W - 1;

  localparam logic [7:0] OFF_WORD     = 8'h00;
  localparam logic [7:0] OFF_FULL_EN  = 8'h04;
  localparam logic [7:0] OFF_EMPTY_EN = 8'h08;
  localparam logic [7:0] OFF_TAG      = 8'h40;
  localparam logic [7:0] OFF_DATA0    = 8'h48;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_WORD,
    SEL_TAG,
    SEL_DATA,
    SEL_FEN,
    SEL_EEN
  } rdSelT;

  typedef struct packed {
    logic                  wrWord;
    logic                  wrTag;
    logic [DATA_WORDS-1:0] wrData;
    logic                  wrFullEn;
    logic                  wrEmptyEn;
    rdSelT                 rdSel;
    logic [IDX_W-1:0]      rdIdx;
  } mbStrobeT;

  function automatic logic [7:0] dataOff(input int idx);
    return OFF_DATA0 + 8'(4 * idx);
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter bit WIDE   = 1'b0,
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output mbStrobeT          strb
);
  logic [DATA_WORDS-1:0] dataHit;
  logic [IDX_W-1:0]      dataIdx;

  always_comb begin
    dataHit = '0;
    dataIdx = '0;
    for (int i = 0; i < DATA_WORDS; i++) begin
      if (WIDE && addr == ADDR_W'(dataOff(i))) begin
        dataHit[i] = 1'b1;
        dataIdx    = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (addr == ADDR_W'(OFF_FULL_EN)) begin
      strb.rdSel    = SEL_FEN;
      strb.wrFullEn = wrEn;
    end else if (addr == ADDR_W'(OFF_EMPTY_EN)) begin
      strb.rdSel     = SEL_EEN;
      strb.wrEmptyEn = wrEn;
    end else if (!WIDE && addr == ADDR_W'(OFF_WORD)) begin
      strb.rdSel  = SEL_WORD;
      strb.wrWord = wrEn;
    end else if (WIDE && addr == ADDR_W'(OFF_TAG)) begin
      strb.rdSel = SEL_TAG;
      strb.wrTag = wrEn;
    end else if (|dataHit) begin
      strb.rdSel  = SEL_DATA;
      strb.rdIdx  = dataIdx;
      strb.wrData = dataHit & {DATA_WORDS{wrEn}};
    end
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbStrobeT          strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              fullBit,
  output logic              fullIrq,
  output logic              emptyIrq
);
  logic [WORD_W-1:0]                  wordQ;
  logic [WORD_W-1:0]                  tagQ;
  logic [DATA_WORDS-1:0][WORD_W-1:0]  dataQ;
  logic                               fullEnQ;
  logic                               emptyEnQ;

  generate
    if (WIDE) begin : g_wide
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tagQ  <= '0;
          dataQ <= '0;
        end else begin
          if (strb.wrTag) tagQ <= wrData;
          for (int i = 0; i < DATA_WORDS; i++) begin
            if (strb.wrData[i]) dataQ[i] <= wrData;
          end
        end
      end
      assign wordQ   = '0;
      assign fullBit = tagQ[FLAG_BIT];
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) wordQ <= '0;
        else if (strb.wrWord) wordQ <= wrData;
      end
      assign tagQ    = '0;
      assign dataQ   = '0;
      assign fullBit = wordQ[FLAG_BIT];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullEnQ  <= 1'b0;
      emptyEnQ <= 1'b0;
    end else begin
      if (strb.wrFullEn)  fullEnQ  <= wrData[0];
      if (strb.wrEmptyEn) emptyEnQ <= wrData[0];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_WORD: rdData = wordQ;
      SEL_TAG:  rdData = tagQ;
      SEL_DATA: rdData = dataQ[strb.rdIdx];
      SEL_FEN:  rdData = {{(WORD_W-1){1'b0}}, fullEnQ};
      SEL_EEN:  rdData = {{(WORD_W-1){1'b0}}, emptyEnQ};
      default:  rdData = '0;
    endcase
  end

  assign fullIrq  = fullBit & fullEnQ;
  assign emptyIrq = ~fullBit & emptyEnQ;
endmodule

// File: rtl/mbox_shared.sv
module mbox_shared
  import mbox_pkg::*;
#(
  parameter bit WIDE   = 1'b0,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              fullOut,
  output logic              emptyOut,
  output logic              fullIrq,
  output logic              emptyIrq
);
  mbStrobeT strb;
  logic     fullBit;

  mbox_ctrl #(.WIDE(WIDE), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  mbox_datapath #(.WIDE(WIDE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .fullBit  (fullBit),
    .fullIrq  (fullIrq),
    .emptyIrq (emptyIrq)
  );

  assign fullOut  = fullBit;
  assign emptyOut = ~fullBit;
endmodule

// File: rtl/mbox_shared_chk.sv
module mbox_shared_chk
  import mbox_pkg::*;
#(
  parameter bit WIDE   = 1'b0,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              fullOut,
  input logic              emptyOut,
  input logic              fullIrq,
  input logic              emptyIrq
);
  localparam logic [ADDR_W-1:0] FLAG_OFF = WIDE ? ADDR_W'(OFF_TAG) : ADDR_W'(OFF_WORD);

  p_set_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == FLAG_OFF && wrData[31]) |=> fullOut);

  p_clear_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == FLAG_OFF && wrData == 32'h0) |=> emptyOut);

  p_enable_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_FULL_EN) && !wrData[0]) |=> !fullIrq);

  p_full_irq_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    fullIrq |-> fullOut);

  p_empty_irq_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |-> emptyOut);

  // R6 and R7: only the flag-carrying word can move the flag
  p_flag_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != FLAG_OFF) |=> $stable(fullOut));

  p_complement_r8: assert property (@(posedge clk) disable iff (!rstN)
    emptyOut != fullOut);
endmodule

bind mbox_shared mbox_shared_chk #(.WIDE(WIDE), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .fullOut  (fullOut),
  .emptyOut (emptyOut),
  .fullIrq  (fullIrq),
  .emptyIrq (emptyIrq)
);

// File: tb/mbox_shared_test.sv
`timescale 1ns/1ps
module mbox_shared_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wrData = 32'h0;
  logic [1:0][31:0] rdData;
  logic [1:0] fullO, emptyO, fullI, emptyI;

  int cmpCnt = 0;
  int misCnt = 0;
  bit done = 1'b0;

  // reference model: index 0 = narrow layout, 1 = wide layout
  logic [31:0] mWord, mTag;
  logic [31:0] mData [4];
  logic [1:0]  mFe, mEe;

  always #10 clk = ~clk;

  mbox_shared #(.WIDE(1'b0), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData[0]), .fullOut(fullO[0]), .emptyOut(emptyO[0]),
    .fullIrq(fullI[0]), .emptyIrq(emptyI[0]));

  mbox_shared #(.WIDE(1'b1), .ADDR_W(8)) uutWide (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData[1]), .fullOut(fullO[1]), .emptyOut(emptyO[1]),
    .fullIrq(fullI[1]), .emptyIrq(emptyI[1]));

  function automatic logic [31:0] expRd(int m, logic [7:0] a);
    if (a == 8'h04) return {31'b0, mFe[m]};
    if (a == 8'h08) return {31'b0, mEe[m]};
    if (m == 0 && a == 8'h00) return mWord;
    if (m == 1 && a == 8'h40) return mTag;
    for (int i = 0; i < 4; i++)
      if (m == 1 && a == 8'(8'h48 + 4 * i)) return mData[i];
    return 32'h0;
  endfunction

  function automatic logic expFull(int m);
    return (m == 0) ? mWord[31] : mTag[31];
  endfunction

  function automatic logic [7:0] pickAddr(int k);
    case (k)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h08;
      3: return 8'h40;  4: return 8'h48;  5: return 8'h4C;
      6: return 8'h50;  7: return 8'h54;  8: return 8'h20;
      default: return 8'h3C;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    cmpCnt++;
    if (act !== exp) begin
      misCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkFlags(string req);
    for (int m = 0; m < 2; m++) begin
      chk({req, " fullOut"},  {31'b0, fullO[m]},  {31'b0, expFull(m)});
      chk({req, " emptyOut R8"}, {31'b0, emptyO[m]}, {31'b0, !expFull(m)});
      chk({req, " fullIrq R5"},  {31'b0, fullI[m]},  {31'b0, expFull(m) & mFe[m]});
      chk({req, " emptyIrq R5"}, {31'b0, emptyI[m]}, {31'b0, !expFull(m) & mEe[m]});
    end
  endtask

  task automatic readCheck(string req, logic [7:0] a);
    @(negedge clk);
    wrEn = 1'b0;
    addr = a;
    #1;
    for (int m = 0; m < 2; m++) chk({req, " rdData"}, rdData[m], expRd(m, a));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    addr = a;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 8'h04) mFe = {2{d[0]}};
    if (a == 8'h08) mEe = {2{d[0]}};
    if (a == 8'h00) mWord = d;
    if (a == 8'h40) mTag = d;
    for (int i = 0; i < 4; i++) if (a == 8'(8'h48 + 4 * i)) mData[i] = d;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, misCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    cmpCnt++;
    misCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    mWord = '0; mTag = '0; mFe = '0; mEe = '0;
    for (int i = 0; i < 4; i++) mData[i] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkFlags("R1");
    for (int k = 0; k < 10; k++) readCheck("R1", pickAddr(k));

    // R4: enables keep bit 0 only
    wr(8'h04, 32'hFFFF_FFFF);
    readCheck("R4", 8'h04);
    wr(8'h08, 32'h0000_0001);
    readCheck("R4", 8'h08);
    checkFlags("R4/R5 enabled empty");

    // R2: narrow send; wide layout ignores 0x00 (R7)
    wr(8'h00, 32'h8000_1234);
    checkFlags("R2/R7");
    readCheck("R2", 8'h00);
    wr(8'h00, 32'h7FFF_FFFF);
    checkFlags("R2 payload without flag");
    wr(8'h00, 32'hC0DE_0001);
    checkFlags("R2");

    // R4: disabling full interrupt while full
    wr(8'h04, 32'hFFFF_FFFE);
    readCheck("R4", 8'h04);
    checkFlags("R4 disabled");
    wr(8'h04, 32'h1);

    // R3: narrow consumer clears word
    wr(8'h00, 32'h0);
    checkFlags("R3 narrow");
    readCheck("R3", 8'h00);

    // R6: wide send, data words do not move the flag
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h48 + 4 * i), 32'hA5A5_0000 | 32'(i) | 32'h8000_0000);
      checkFlags("R6 data write");
    end
    wr(8'h40, 32'h8000_0000);
    checkFlags("R6 tag");
    for (int i = 0; i < 4; i++) readCheck("R6", 8'(8'h48 + 4 * i));

    // R3: wide consumer clears data then tag
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h48 + 4 * i), 32'h0);
      checkFlags("R3 wide data clear");
    end
    wr(8'h40, 32'h0);
    checkFlags("R3 wide");
    readCheck("R3", 8'h40);

    // R7: unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    checkFlags("R7");
    readCheck("R7", 8'h20);
    readCheck("R7", 8'h3C);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = pickAddr(int'($urandom_range(0, 9)));
      d = $urandom();
      wr(a, d);
      checkFlags("R2/R3/R5/R6/R7 random");
      readCheck("R2/R4/R6/R7 random", pickAddr(int'($urandom_range(0, 9))));
    end

    finishRun();
  end
endmodule